// File: doc/BRIEF.md
# Audio Receive Queue with Frame-Counted Timeout

This block buffers 32-bit audio words that a slot packer delivers and hands them, oldest first, to a CPU-side reader. The oldest stored word is always visible on the read data port while the queue holds anything; a read request removes it. A configuration strobe loads two settings together: a mode bit and a frame limit. The mode bit limits the queue to a single holding register. The frame limit sets how many frame sync pulses may pass with data waiting and nothing new arriving before the timeout interrupt is raised.

The timeout is measured in frames, not clock cycles. The frame counter advances only on a frame sync pulse. It restarts on every accepted write, and it is held at zero whenever the queue is empty. A frame limit of zero turns the timeout off. The interrupt stays raised until a word is read or the configuration is written again. After it has fired, it cannot fire again until a new word has been accepted.

Top module: `rxq_frame_fifo`

## Requirements
- R1: After reset, empty is 1, full, tmo_irq and overrun are 0, the mode bit is 0 (queue mode) and the frame limit is 0.
- R2: Words leave in the order they were accepted. rd_data shows the oldest stored word while empty is 0, and a read request with empty at 0 removes that word.
- R3: In queue mode the block holds up to 8 words. full is 1 exactly when 8 words are stored, and empty is 1 exactly when none are stored.
- R4: A write while full is 1 is dropped and leaves the stored words unchanged. It sets overrun, which stays at 1 until the next configuration write clears it.
- R5: With the mode bit at 1 the block holds a single word. full goes to 1 after one write, and a second write is dropped and sets overrun.
- R6: A configuration write that changes the mode bit discards every stored word. A configuration write that keeps the mode bit leaves the stored words in place.
- R7: With a nonzero frame limit N and data stored, tmo_irq goes to 1 in the cycle after the N-th frame sync pulse counted since the last accepted write. Clock cycles without a frame sync pulse do not advance the count.
- R8: With a frame limit of 0, tmo_irq never goes to 1, whatever data and frame pulses arrive.
- R9: An accepted write restarts the frame count from zero. Frame pulses that arrive while the queue is empty are not counted.
- R10: tmo_irq stays at 1 through further frame pulses until a read is accepted or a configuration write occurs. After firing it does not fire again until a new word is accepted and another N frames pass.
- R11: A read request while empty is 1 has no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Word offered by the slot packer this cycle |
| wr_data | input | 32 | Offered audio word |
| rd_req | input | 1 | Remove the word shown on rd_data |
| rd_data | output | 32 | Oldest stored word (valid while empty is 0) |
| frame_sync | input | 1 | One-cycle pulse per audio frame |
| cfg_we | input | 1 | Load cfg_hold and cfg_frame_limit |
| cfg_hold | input | 1 | 1 selects single holding register, 0 selects 8-entry queue |
| cfg_frame_limit | input | 13 | Frames to wait before timeout, 0 disables, up to 4096 |
| empty | output | 1 | No word stored |
| full | output | 1 | No room for another word in the current mode |
| tmo_irq | output | 1 | Frame timeout interrupt |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The queue is tried with three distinct word patterns read back in order, with a run of eight writes followed by one extra, and with single-word writes in holding mode. Between them these separate wrong ordering, wrong capacity and a dropped word that was stored anyway. The timeout is tried with long idle stretches that have no frame pulses, to separate a frame count from a clock count. A write placed in the middle of a frame run shows whether the count restarts. Frame pulses sent while the queue is empty show whether the counter is held at zero. Further pulses after firing, a read, and a fresh write show whether the interrupt holds, clears and re-arms at the right points. A limit of zero and configuration writes that do and do not change the mode bit complete the cases.

// File: rtl/rxq_pkg.sv
// Package: shared sizes and the configuration record for the receive queue.
// Assumes the frame limit must hold the value 4096, hence 13 bits.
package rxq_pkg;
    localparam int WORD_W    = 32;
    localparam int Q_DEPTH   = 8;
    localparam int MAX_FRAMES = 4096;
    localparam int TMO_W     = $clog2(MAX_FRAMES + 1);

    typedef struct packed {
        logic             hold_mode;
        logic [TMO_W-1:0] frame_limit;
    } rxq_cfg_t;
endpackage

// File: rtl/rxq_cfg.sv
// Module: configuration holder. Loads the mode bit and frame limit on cfg_we.
// Produces a same-cycle flush request when a load changes the mode bit.
// Assumes cfg_we is a single-cycle strobe from the register side.
module rxq_cfg
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_hold,
    input  logic [TMO_W-1:0] cfg_frame_limit,
    output rxq_cfg_t         cfg_q,
    output logic             flush
);
    // Flush request: a load that flips the storage mode.
    always_comb begin
        flush = cfg_we && (cfg_hold != cfg_q.hold_mode);
    end

    // Configuration register with zero reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.hold_mode   <= cfg_hold;
            cfg_q.frame_limit <= cfg_frame_limit;
        end
    end

    // R6
    mode_flip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_hold != cfg_q.hold_mode) |-> flush);
endmodule

// File: rtl/rxq_store.sv
// Module: word storage with a mode-dependent capacity. One circular array
// serves both modes. In holding mode the capacity is capped at one entry.
// Read data is shown ahead from the head entry. Assumes flush is raised only
// together with a mode change, so the level never exceeds the new capacity.
module rxq_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_mode,
    input  logic              flush,
    input  logic              ovr_clr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_acc,
    output logic              rd_acc,
    output logic              empty,
    output logic              full,
    output logic              overrun
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CNT_W-1:0]  level;
    logic [CNT_W-1:0]  cap;

    // Advance a pointer with wrap at DEPTH (any depth, not only powers of two).
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Capacity and status decode.
    always_comb begin
        cap    = hold_mode ? CNT_W'(1) : CNT_W'(DEPTH);
        full   = (level >= cap);
        empty  = (level == '0);
        wr_acc = wr_valid && !full && !flush;
        rd_acc = rd_req && !empty && !flush;
    end

    // Show-ahead read of the head entry.
    always_comb begin
        rd_data = mem[rd_ptr];
    end

    // Entry writes at the tail pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_acc && wr_ptr == AW'(i)) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Pointer and level bookkeeping, with flush to the empty state.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_acc) wr_ptr <= bump(wr_ptr);
            if (rd_acc) rd_ptr <= bump(rd_ptr);
            case ({wr_acc, rd_acc})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Sticky overrun: set by a refused write, cleared by a configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clr) begin
            overrun <= 1'b0;
        end else if (wr_valid && full) begin
            overrun <= 1'b1;
        end
    end

    // R4
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !rd_req && !flush) |=> (full && level == $past(level)));
    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
    // R5
    hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode && !empty) |-> full);
    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    // R11
    empty_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_valid) |=> empty);
endmodule

// File: rtl/rxq_frame_timer.sv
// Module: frame-counted timeout. Counts frame sync pulses while data waits
// and no write arrives, and raises the interrupt when the count reaches the
// programmed limit. A limit of zero disables it. After firing it stays
// quiet until a fresh write re-arms it. Assumes frame_sync is one cycle wide.
module rxq_frame_timer
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             wr_acc,
    input  logic             rd_acc,
    input  logic             empty,
    input  logic             cfg_we,
    input  logic [TMO_W-1:0] frame_limit,
    output logic             tmo_irq
);
    logic [TMO_W-1:0] frames;
    logic             spent;
    logic             enabled;
    logic             counting;
    logic             fire;

    // Counting conditions and the firing event.
    always_comb begin
        enabled  = (frame_limit != '0);
        counting = frame_sync && enabled && !empty && !spent && !wr_acc && !cfg_we;
        fire     = counting && ((frames + 1'b1) == frame_limit);
    end

    // Frame counter: restarted by writes, an empty queue or a configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_acc || empty || cfg_we) begin
            frames <= '0;
        end else if (counting) begin
            frames <= frames + 1'b1;
        end
    end

    // Re-arm flag: set on firing, cleared by the next accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_acc) begin
            spent <= 1'b0;
        end else if (fire) begin
            spent <= 1'b1;
        end
    end

    // Interrupt: held until a read or a configuration load clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_acc || cfg_we) begin
            tmo_irq <= 1'b0;
        end else if (fire) begin
            tmo_irq <= 1'b1;
        end
    end

    // R8
    no_irq_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_limit == '0) |-> !tmo_irq);
    // R7
    irq_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> $past(frame_sync));
    // R7
    irq_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> !empty);
    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc || cfg_we) |=> !tmo_irq);
    // R9
    empty_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (frames == '0));
endmodule

// File: rtl/rxq_frame_fifo.sv
// Module: top of the audio receive queue. Ties the configuration holder,
// the word storage and the frame timer together. Assumes single-clock use
// with the slot packer, reader and frame pulse all synchronous to clk.
module rxq_frame_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int DEPTH  = Q_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_sync,
    input  logic              cfg_we,
    input  logic              cfg_hold,
    input  logic [TMO_W-1:0]  cfg_frame_limit,
    output logic              empty,
    output logic              full,
    output logic              tmo_irq,
    output logic              overrun
);
    rxq_cfg_t cfg_q;
    logic     flush;
    logic     wr_acc;
    logic     rd_acc;

    rxq_cfg u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_hold        (cfg_hold),
        .cfg_frame_limit (cfg_frame_limit),
        .cfg_q           (cfg_q),
        .flush           (flush)
    );

    rxq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_mode (cfg_q.hold_mode),
        .flush     (flush),
        .ovr_clr   (cfg_we),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .empty     (empty),
        .full      (full),
        .overrun   (overrun)
    );

    rxq_frame_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .wr_acc      (wr_acc),
        .rd_acc      (rd_acc),
        .empty       (empty),
        .cfg_we      (cfg_we),
        .frame_limit (cfg_q.frame_limit),
        .tmo_irq     (tmo_irq)
    );
endmodule

// File: tb/rxq_frame_fifo_bench.sv
`timescale 1ns/1ps
module rxq_frame_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        frame_sync = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_hold = 1'b0;
    logic [12:0] cfg_frame_limit = '0;
    logic        empty, full, tmo_irq, overrun;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    rxq_frame_fifo u_rxq_frame_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .frame_sync(frame_sync),
        .cfg_we(cfg_we), .cfg_hold(cfg_hold), .cfg_frame_limit(cfg_frame_limit),
        .empty(empty), .full(full), .tmo_irq(tmo_irq), .overrun(overrun)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); wr_valid = 1'b1; wr_data = w;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic pop(input string req, input logic [31:0] exp);
        @(negedge clk);
        check(req, "head word", rd_data, exp);
        rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic sync(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); frame_sync = 1'b1;
            @(negedge clk); frame_sync = 1'b0;
        end
    endtask

    task automatic cfg(input logic hold, input logic [12:0] lim);
        @(negedge clk); cfg_we = 1'b1; cfg_hold = hold; cfg_frame_limit = lim;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "empty", 32'(empty), 1);
        check("R1", "full", 32'(full), 0);
        check("R1", "tmo_irq", 32'(tmo_irq), 0);
        check("R1", "overrun", 32'(overrun), 0);
        push(32'h0000_0011);
        sync(6);
        check("R1", "limit zero after reset, no irq", 32'(tmo_irq), 0);
        check("R1", "queue mode after reset, not full", 32'(full), 0);
        pop("R1", 32'h0000_0011);
    endtask

    task automatic t_order();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check("R11", "empty after read on empty", 32'(empty), 1);
        push(32'hA5A5_0001); push(32'h5A5A_0002); push(32'hFFFF_0003);
        check("R3", "not empty", 32'(empty), 0);
        pop("R2", 32'hA5A5_0001);
        pop("R2", 32'h5A5A_0002);
        pop("R2", 32'hFFFF_0003);
        check("R3", "empty after drain", 32'(empty), 1);
        push(32'h1234_5678);
        pop("R11", 32'h1234_5678);
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) begin
            check("R3", "not full before 8", 32'(full), 0);
            push(32'h100 + 32'(i));
        end
        check("R3", "full at 8", 32'(full), 1);
        check("R4", "no overrun yet", 32'(overrun), 0);
        push(32'hDEAD_BEEF);
        check("R4", "overrun set", 32'(overrun), 1);
        for (int i = 0; i < 8; i++) pop("R4", 32'h100 + 32'(i));
        check("R4", "empty, extra word not stored", 32'(empty), 1);
        check("R4", "overrun sticky", 32'(overrun), 1);
        cfg(1'b0, 13'd0);
        check("R4", "overrun cleared by cfg", 32'(overrun), 0);
    endtask

    task automatic t_hold();
        cfg(1'b1, 13'd0);
        push(32'hCAFE_0001);
        check("R5", "full after one word", 32'(full), 1);
        push(32'hCAFE_0002);
        check("R5", "overrun on second word", 32'(overrun), 1);
        pop("R5", 32'hCAFE_0001);
        check("R5", "empty after read", 32'(empty), 1);
        push(32'hCAFE_0003);
        cfg(1'b0, 13'd0);
        check("R6", "mode change flushes", 32'(empty), 1);
        push(32'h0000_0A01); push(32'h0000_0A02);
        cfg(1'b0, 13'd0);
        check("R6", "same mode keeps data", 32'(empty), 0);
        cfg(1'b1, 13'd0);
        check("R6", "flush from queue mode", 32'(empty), 1);
        cfg(1'b0, 13'd0);
    endtask

    task automatic t_timeout();
        cfg(1'b0, 13'd3);
        push(32'h0000_00B1); push(32'h0000_00B2);
        repeat (100) @(negedge clk);
        check("R7", "idle clocks not counted", 32'(tmo_irq), 0);
        sync(2);
        check("R7", "two of three frames", 32'(tmo_irq), 0);
        sync(1);
        check("R7", "fires on third frame", 32'(tmo_irq), 1);
        sync(5);
        check("R10", "held across frames", 32'(tmo_irq), 1);
        pop("R10", 32'h0000_00B1);
        check("R10", "cleared by read", 32'(tmo_irq), 0);
        sync(5);
        check("R10", "no re-fire without new data", 32'(tmo_irq), 0);
        push(32'h0000_00B3);
        sync(2);
        check("R10", "re-armed, two frames", 32'(tmo_irq), 0);
        sync(1);
        check("R10", "re-fires after new write", 32'(tmo_irq), 1);
        cfg(1'b0, 13'd3);
        check("R10", "cleared by cfg write", 32'(tmo_irq), 0);
        pop("R10", 32'h0000_00B2);
        pop("R10", 32'h0000_00B3);
    endtask

    task automatic t_restart();
        push(32'h0000_00C1);
        sync(2);
        push(32'h0000_00C2);
        sync(2);
        check("R9", "write restarts count", 32'(tmo_irq), 0);
        sync(1);
        check("R9", "fires 3 frames after last write", 32'(tmo_irq), 1);
        pop("R9", 32'h0000_00C1);
        pop("R9", 32'h0000_00C2);
        sync(5);
        push(32'h0000_00C3);
        sync(2);
        check("R9", "frames while empty not counted", 32'(tmo_irq), 0);
        sync(1);
        check("R9", "fires after full period", 32'(tmo_irq), 1);
        pop("R9", 32'h0000_00C3);
        cfg(1'b0, 13'd0);
        push(32'h0000_00D1);
        sync(8);
        check("R8", "limit zero never fires", 32'(tmo_irq), 0);
        pop("R8", 32'h0000_00D1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_hold();
        t_timeout();
        t_restart();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule